// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a page table kept in memory. A walk begins at the context table. The entry fetched there points to a first-level directory. Each directory entry points one level down, and an entry that is a page table entry ends the walk. A leaf found at level 1 maps a 16 MB page, at level 2 a 256 KB page, and at level 3 a 4 KB page. The block reads 32-bit words over a single-outstanding request/response memory port. When the referenced or modified flag of the leaf has to change, it writes the leaf back to the address it was read from.

A requester pulses a start input with the address and the kind of access. `busy_o` stays high until a one-cycle `done_o` pulse returns either the physical address and page size or a fault code. The fault code holds the level in bits [9:8] and the fault type in bits [4:2]. In bypass mode no memory is touched and the virtual address passes straight through. The exception is an instruction fetch while boot mode is set, which is steered into a boot ROM window. Permission checks, fault status registers and translation caching are handled outside this block.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to (context table pointer << 4) + (context number << 2), with the pointer zero-extended to 36 bits.
- R2: After a directory entry (low two bits 01) read at level L < 3, the next read goes to ({entry[31:2], 2'b00} << 4) plus an index. The index is VA[31:24]*4 for level 1, VA[23:18]*4 for level 2 and VA[17:12]*4 for level 3.
- R3: An entry whose low two bits are 00, read at level L, ends the walk with `fault_o`=1 and `fault_code_o` = (L << 8) | (1 << 2).
- R4: A reserved entry (low bits 11) read at level L ends the walk with code (L << 8) | (4 << 2). So does a bus error on any transaction of level L. After a bus error no further transaction is issued.
- R5: A leaf entry (low bits 10) in the context table, or a directory entry at level 3, ends the walk with code (L << 8) | (4 << 2).
- R6: A leaf at level 1, 2 or 3 gives `page_size_o` of 2, 1 or 0. `pa_o` is ({entry[31:8], 12'b0}) plus VA[23:0], VA[17:0] or VA[11:0] respectively, and `fault_o`=0.
- R7: Bit 5 of a leaf is the referenced flag and bit 6 the modified flag. If bit 5 is clear, or the access is a write and bit 6 is clear, the leaf is written back to its own address with bit 5 set and, for a write, bit 6 set. Otherwise no write is issued.
- R8: In bypass mode the walk issues no memory transaction and `done_o` rises one cycle after start with page size 0. `pa_o` is the prom base ORed with VA[18:0] for an instruction fetch with boot mode set, and the zero-extended VA in every other case.
- R9: `busy_o` is high from the cycle after start until `done_o`. `done_o` is a single-cycle pulse. Request, address and write flag hold steady until a response arrives. A start that arrives while busy is ignored.
- R10: Reset leaves `busy_o`, `done_o` and `mem_req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a translation |
| va_i | input | 32 | Virtual address |
| write_i | input | 1 | Access is a store |
| fetch_i | input | 1 | Access is an instruction fetch |
| bypass_i | input | 1 | Physical (untranslated) mode |
| boot_i | input | 1 | Boot mode flag |
| ctx_ptr_i | input | 32 | Context table pointer |
| ctx_num_i | input | 8 | Context number |
| prom_base_i | input | 36 | Boot ROM window base |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid pulse |
| fault_o | output | 1 | Walk ended in a fault |
| fault_code_o | output | 10 | Level [9:8], type [4:2] |
| pa_o | output | 36 | Physical address |
| page_size_o | output | 2 | 0 = 4 KB, 1 = 256 KB, 2 = 16 MB |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 36 | Memory word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data |
| mem_ack_i | input | 1 | Transaction complete |
| mem_err_i | input | 1 | Transaction failed |

## Verification
A wrong level counter shows up on the next read. That read uses the wrong VA slice, so its address differs from the one the bench expects. A wrong level also puts a wrong level field into a fault code. A leaf decoded at the wrong size shows in `pa_o` and `page_size_o` on the `done_o` cycle. A bad flag update shows as a missing or extra write-back, or as wrong write data, in the transaction after the leaf read. Each transaction is compared as it completes, and the result is compared in the cycle `done_o` is high.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int VA_W   = 32;
  localparam int ENT_W  = 32;
  localparam int PTR_W  = 32;
  localparam int PA_W   = PTR_W + 4;
  localparam int LVL_W  = 2;
  localparam int CODE_W = 10;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_TRANS   = 3'd4;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_DIR     = 2'd1,
    ET_LEAF    = 2'd2,
    ET_RSVD    = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    SZ_4K   = 2'd0,
    SZ_256K = 2'd1,
    SZ_16M  = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    DEC_DESCEND = 2'd0,
    DEC_LEAF    = 2'd1,
    DEC_FAULT   = 2'd2
  } dec_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WBACK = 2'd2
  } walk_st_e;
endpackage

// File: rtl/pt_walk_decode.sv
module pt_walk_decode
  import pt_walk_pkg::*;
(
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [ENT_W-1:0] entry_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             wr_i,
  output dec_kind_e        kind_o,
  output logic [2:0]       ftype_o,
  output logic [PA_W-1:0]  next_addr_o,
  output logic [PA_W-1:0]  leaf_pa_o,
  output pg_size_e         leaf_size_o,
  output logic             wb_need_o,
  output logic [ENT_W-1:0] wb_data_o
);
  localparam int NUM_LVL = 1 << LVL_W;

  logic [PA_W-1:0]  idx [NUM_LVL];
  logic [LVL_W-1:0] nxt_lvl;
  logic [PA_W-1:0]  dir_base;
  logic [PA_W-1:0]  frame;
  logic [PA_W-1:0]  offset;
  ent_type_e        etype;

  // Per-level table index, one slice of the VA per directory level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_idx
    if (l == 0) begin : g_none
      assign idx[l] = '0;
    end else begin : g_slice
      localparam int HI = (l == 1) ? 31 : (l == 2) ? 23 : 17;
      localparam int LO = (l == 1) ? 24 : (l == 2) ? 18 : 12;
      assign idx[l] = PA_W'({va_i[HI:LO], 2'b00});
    end
  end

  assign nxt_lvl     = lvl_i + 1'b1;
  assign dir_base    = {entry_i[ENT_W-1:2], 6'b000000};
  assign next_addr_o = dir_base + idx[nxt_lvl];

  assign frame = {entry_i[ENT_W-1:8], 12'h000};
  always_comb begin
    case (lvl_i)
      2'd1:    begin offset = PA_W'(va_i[23:0]); leaf_size_o = SZ_16M;  end
      2'd2:    begin offset = PA_W'(va_i[17:0]); leaf_size_o = SZ_256K; end
      default: begin offset = PA_W'(va_i[11:0]); leaf_size_o = SZ_4K;   end
    endcase
  end
  assign leaf_pa_o = frame + offset;

  assign etype = ent_type_e'(entry_i[1:0]);
  always_comb begin
    kind_o  = DEC_FAULT;
    ftype_o = FT_TRANS;
    case (etype)
      ET_INVALID: ftype_o = FT_INVALID;
      ET_DIR:     if (lvl_i != 2'd3) kind_o = DEC_DESCEND;
      ET_LEAF:    if (lvl_i != 2'd0) kind_o = DEC_LEAF;
      default:    ftype_o = FT_TRANS;
    endcase
  end

  assign wb_need_o = !entry_i[REF_BIT] || (wr_i && !entry_i[MOD_BIT]);
  always_comb begin
    wb_data_o = entry_i;
    wb_data_o[REF_BIT] = 1'b1;
    if (wr_i) wb_data_o[MOD_BIT] = 1'b1;
  end
endmodule

// File: rtl/pt_walk_bypass.sv
module pt_walk_bypass
  import pt_walk_pkg::*;
#(
  parameter int BOOT_WIN_W = 19
) (
  input  logic [VA_W-1:0] va_i,
  input  logic            fetch_i,
  input  logic            boot_i,
  input  logic [PA_W-1:0] prom_base_i,
  output logic [PA_W-1:0] pa_o
);
  logic [PA_W-1:0] boot_pa;
  assign boot_pa = prom_base_i | PA_W'(va_i[BOOT_WIN_W-1:0]);
  assign pa_o    = (fetch_i && boot_i) ? boot_pa : PA_W'(va_i);
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bypass_i,
  input  logic              write_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [PA_W-1:0]   first_addr_i,
  input  logic [PA_W-1:0]   bypass_pa_i,
  input  dec_kind_e         kind_i,
  input  logic [2:0]        ftype_i,
  input  logic [PA_W-1:0]   next_addr_i,
  input  logic [PA_W-1:0]   leaf_pa_i,
  input  pg_size_e          leaf_size_i,
  input  logic              wb_need_i,
  input  logic [ENT_W-1:0]  wb_data_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [VA_W-1:0]   va_o,
  output logic              wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [CODE_W-1:0] fault_code_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [1:0]        page_size_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [ENT_W-1:0]  mem_wdata_o
);
  walk_st_e          st_q, st_n;
  logic [LVL_W-1:0]  lvl_q, lvl_n;
  logic [VA_W-1:0]   va_q, va_n;
  logic              wr_q, wr_n;
  logic              req_q, req_n, we_q, we_n, done_q, done_n;
  logic [PA_W-1:0]   addr_q, addr_n;
  logic [ENT_W-1:0]  wdata_q, wdata_n;
  logic              fault_q, fault_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [PA_W-1:0]   pa_q, pa_n;
  pg_size_e          size_q, size_n;
  logic              ctx_en, res_en, map_en;

  function automatic logic [CODE_W-1:0] mk_code(logic [LVL_W-1:0] l, logic [2:0] t);
    return {l, 3'b000, t, 2'b00};
  endfunction

  always_comb begin
    st_n = st_q; lvl_n = lvl_q; va_n = va_q; wr_n = wr_q;
    req_n = req_q; we_n = we_q; addr_n = addr_q; wdata_n = wdata_q;
    done_n = 1'b0;
    fault_n = fault_q; code_n = code_q; pa_n = pa_q; size_n = size_q;
    ctx_en = 1'b0; res_en = 1'b0; map_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (bypass_i) begin
            done_n = 1'b1; res_en = 1'b1; map_en = 1'b1;
            fault_n = 1'b0; code_n = '0;
            pa_n = bypass_pa_i; size_n = SZ_4K;
          end else begin
            st_n = ST_READ; lvl_n = '0; ctx_en = 1'b1;
            va_n = va_i; wr_n = write_i;
            addr_n = first_addr_i; req_n = 1'b1; we_n = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (mem_err_i) begin
          st_n = ST_IDLE; req_n = 1'b0; done_n = 1'b1; res_en = 1'b1;
          fault_n = 1'b1; code_n = mk_code(lvl_q, FT_TRANS);
        end else if (mem_ack_i) begin
          case (kind_i)
            DEC_DESCEND: begin
              addr_n = next_addr_i;
              lvl_n  = lvl_q + 1'b1;
            end
            DEC_LEAF: begin
              map_en = 1'b1; pa_n = leaf_pa_i; size_n = leaf_size_i;
              if (wb_need_i) begin
                st_n = ST_WBACK; we_n = 1'b1; wdata_n = wb_data_i;
              end else begin
                st_n = ST_IDLE; req_n = 1'b0; done_n = 1'b1; res_en = 1'b1;
                fault_n = 1'b0; code_n = '0;
              end
            end
            default: begin
              st_n = ST_IDLE; req_n = 1'b0; done_n = 1'b1; res_en = 1'b1;
              fault_n = 1'b1; code_n = mk_code(lvl_q, ftype_i);
            end
          endcase
        end
      end
      ST_WBACK: begin
        if (mem_err_i || mem_ack_i) begin
          st_n = ST_IDLE; req_n = 1'b0; we_n = 1'b0;
          done_n = 1'b1; res_en = 1'b1;
          fault_n = mem_err_i;
          code_n  = mem_err_i ? mk_code(lvl_q, FT_TRANS) : '0;
        end
      end
      default: begin
        st_n = ST_IDLE; req_n = 1'b0; we_n = 1'b0;
      end
    endcase
  end

  // Control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; lvl_q <= '0; req_q <= 1'b0; we_q <= 1'b0;
      done_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
    end else begin
      st_q <= st_n; lvl_q <= lvl_n; req_q <= req_n; we_q <= we_n;
      done_q <= done_n; addr_q <= addr_n; wdata_q <= wdata_n;
    end
  end

  // Request context, loaded only when a walk is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q <= '0; wr_q <= 1'b0;
    end else if (ctx_en) begin
      va_q <= va_n; wr_q <= wr_n;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0; code_q <= '0;
    end else if (res_en) begin
      fault_q <= fault_n; code_q <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0; size_q <= SZ_4K;
    end else if (map_en) begin
      pa_q <= pa_n; size_q <= size_n;
    end
  end

  assign lvl_o        = lvl_q;
  assign va_o         = va_q;
  assign wr_o         = wr_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign pa_o         = pa_q;
  assign page_size_o  = size_q;
  assign mem_req_o    = req_q;
  assign mem_we_o     = we_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;

  // R9: a pending transaction holds its request, address and direction
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i && !mem_err_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R9: memory traffic only while a walk is active
  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  // R9: the completion pulse arrives with the walker idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R4: a bus error ends the walk at once with a fault
  p_err_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_err_i |=> done_o && fault_o && !mem_req_o);

  // R3: fault codes carry only a level and a legal type
  p_fault_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o |-> fault_code_o[7:5] == 3'b000 && fault_code_o[1:0] == 2'b00 &&
      (fault_code_o[4:2] == FT_INVALID || fault_code_o[4:2] == FT_TRANS));

  // R7: a leaf needing an update is rewritten at the address it came from
  p_wb_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_we_o && mem_ack_i && !mem_err_i && kind_i == DEC_LEAF && wb_need_i
      |=> mem_req_o && mem_we_o && $stable(mem_addr_o));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int CTX_W      = 8,
  parameter int BOOT_WIN_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              write_i,
  input  logic              fetch_i,
  input  logic              bypass_i,
  input  logic              boot_i,
  input  logic [PTR_W-1:0]  ctx_ptr_i,
  input  logic [CTX_W-1:0]  ctx_num_i,
  input  logic [PA_W-1:0]   prom_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [CODE_W-1:0] fault_code_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [1:0]        page_size_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [ENT_W-1:0]  mem_wdata_o,
  input  logic [ENT_W-1:0]  mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i
);
  logic [PA_W-1:0]  first_addr, bypass_pa, next_addr, leaf_pa;
  logic [LVL_W-1:0] lvl;
  logic [VA_W-1:0]  va_held;
  logic             wr_held, wb_need;
  logic [ENT_W-1:0] wb_data;
  logic [2:0]       ftype;
  dec_kind_e        kind;
  pg_size_e         leaf_size;

  assign first_addr = PA_W'({ctx_ptr_i, 4'b0000}) + PA_W'({ctx_num_i, 2'b00});

  pt_walk_bypass #(.BOOT_WIN_W(BOOT_WIN_W)) u_bypass (
    .va_i(va_i), .fetch_i(fetch_i), .boot_i(boot_i),
    .prom_base_i(prom_base_i), .pa_o(bypass_pa)
  );

  pt_walk_decode u_decode (
    .lvl_i(lvl), .entry_i(mem_rdata_i), .va_i(va_held), .wr_i(wr_held),
    .kind_o(kind), .ftype_o(ftype), .next_addr_o(next_addr),
    .leaf_pa_o(leaf_pa), .leaf_size_o(leaf_size),
    .wb_need_o(wb_need), .wb_data_o(wb_data)
  );

  pt_walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bypass_i(bypass_i),
    .write_i(write_i), .va_i(va_i), .first_addr_i(first_addr),
    .bypass_pa_i(bypass_pa), .kind_i(kind), .ftype_i(ftype),
    .next_addr_i(next_addr), .leaf_pa_i(leaf_pa), .leaf_size_i(leaf_size),
    .wb_need_i(wb_need), .wb_data_i(wb_data),
    .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
    .lvl_o(lvl), .va_o(va_held), .wr_o(wr_held),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .fault_code_o(fault_code_o), .pa_o(pa_o), .page_size_o(page_size_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start, wr, fetch, byp, boot;
  logic [31:0] va, ptr;
  logic [7:0]  ctx;
  logic [35:0] prom;
  logic        busy, done, fault, req, we, ack, err;
  logic [9:0]  code;
  logic [35:0] pa, maddr;
  logic [1:0]  psize;
  logic [31:0] wdata, rdata;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .va_i(va), .write_i(wr),
    .fetch_i(fetch), .bypass_i(byp), .boot_i(boot), .ctx_ptr_i(ptr),
    .ctx_num_i(ctx), .prom_base_i(prom), .busy_o(busy), .done_o(done),
    .fault_o(fault), .fault_code_o(code), .pa_o(pa), .page_size_o(psize),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ack_i(ack), .mem_err_i(err)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem [logic [35:0]];
  bit          err_en, err_we;
  logic [35:0] err_addr;
  logic [35:0] log_a [$];
  logic        log_w [$];
  logic [31:0] log_d [$];

  // reference inputs and expectations
  logic [31:0] va_r, ptr_r;
  logic [7:0]  ctx_r;
  logic        wr_r;
  logic        exp_fault, exp_wb;
  logic [9:0]  exp_code;
  logic [35:0] exp_pa, exp_wba;
  logic [1:0]  exp_size;
  logic [31:0] exp_wbd;
  logic [35:0] exp_rd [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory responder: random latency 0..2, error injection, logging
  initial begin
    int wcnt = 0;
    int lat = 0;
    ack = 1'b0; err = 1'b0; rdata = '0;
    forever begin
      @(negedge clk);
      ack = 1'b0; err = 1'b0;
      if (req) begin
        if (wcnt >= lat) begin
          wcnt = 0; lat = int'($urandom % 3);
          log_a.push_back(maddr); log_w.push_back(we); log_d.push_back(wdata);
          if (err_en && we == err_we && maddr == err_addr) err = 1'b1;
          else begin
            ack = 1'b1;
            if (we) mem[maddr] = wdata;
            else rdata = mem.exists(maddr) ? mem[maddr] : 32'h0;
          end
        end else wcnt++;
      end
    end
  end

  function automatic logic [35:0] idx_of(int l, logic [31:0] v);
    case (l)
      1: return 36'({v[31:24], 2'b00});
      2: return 36'({v[23:18], 2'b00});
      default: return 36'({v[17:12], 2'b00});
    endcase
  endfunction

  function automatic logic [35:0] dir_of(logic [31:0] e);
    return {e[31:2], 6'b0};
  endfunction

  function automatic logic [35:0] first_of();
    return {ptr_r, 4'b0} + 36'({ctx_r, 2'b00});
  endfunction

  task automatic flt(input int l, input int t);
    exp_fault = 1'b1;
    exp_code = {2'(l), 3'b000, 3'(t), 2'b00};
  endtask

  task automatic ref_walk();
    logic [35:0] a;
    logic [31:0] e;
    exp_rd.delete(); exp_wb = 0; exp_fault = 0; exp_code = 0;
    exp_pa = 0; exp_size = 0; exp_wba = 0; exp_wbd = 0;
    a = first_of();
    for (int l = 0; l < 4; l++) begin
      exp_rd.push_back(a);
      if (err_en && !err_we && a == err_addr) begin flt(l, 4); return; end
      e = mem.exists(a) ? mem[a] : 32'h0;
      case (e[1:0])
        2'b00: begin flt(l, 1); return; end
        2'b11: begin flt(l, 4); return; end
        2'b01: begin
          if (l == 3) begin flt(l, 4); return; end
          a = dir_of(e) + idx_of(l + 1, va_r);
        end
        default: begin
          if (l == 0) begin flt(l, 4); return; end
          exp_pa = {e[31:8], 12'h0} + ((l == 1) ? 36'(va_r[23:0]) :
                   (l == 2) ? 36'(va_r[17:0]) : 36'(va_r[11:0]));
          exp_size = (l == 1) ? 2'd2 : (l == 2) ? 2'd1 : 2'd0;
          if (!e[5] || (wr_r && !e[6])) begin
            exp_wb = 1; exp_wba = a;
            exp_wbd = e | 32'h20 | (wr_r ? 32'h40 : 32'h0);
            if (err_en && err_we && a == err_addr) flt(l, 4);
          end
          return;
        end
      endcase
    end
  endtask

  // fk: 0 none, 1 invalid, 2 reserved, 3 read bus error, 4 write-back bus error, 5 wrong type
  task automatic build(input int leaf, input int fl, input int fk, input int rm);
    logic [35:0] a;
    logic [31:0] e;
    mem.delete(); err_en = 0; err_we = 0; err_addr = '0;
    ptr_r = $urandom; ctx_r = 8'($urandom); va_r = $urandom;
    a = first_of();
    for (int l = 0; l <= leaf; l++) begin
      e = $urandom;
      e[1:0] = (l < leaf) ? 2'b01 : 2'b10;
      if (l == leaf && rm >= 0) e[6:5] = 2'(rm);
      if (l == fl) begin
        case (fk)
          1: e[1:0] = 2'b00;
          2: e[1:0] = 2'b11;
          3: begin err_en = 1; err_we = 0; err_addr = a; end
          4: begin e[5] = 1'b0; err_en = 1; err_we = 1; err_addr = a; end
          5: e[1:0] = (l == 0) ? 2'b10 : 2'b01;
          default: ;
        endcase
      end
      mem[a] = e;
      if (e[1:0] != 2'b01 || l == 3) break;
      if (l == fl && fk == 3) break;
      a = dir_of(e) + idx_of(l + 1, va_r);
    end
  endtask

  task automatic run(input string tag, input bit poke);
    int n;
    int rd;
    log_a.delete(); log_w.delete(); log_d.delete();
    ref_walk();
    @(negedge clk);
    start = 1; va = va_r; ptr = ptr_r; ctx = ctx_r; wr = wr_r; byp = 0;
    fetch = $urandom; boot = $urandom;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R9 busy after start", 64'(busy), 1);
    if (poke) begin
      start = 1; byp = 1; va = ~va_r; wr = ~wr_r; ptr = ~ptr_r;
      @(negedge clk);
      start = 0; byp = 0;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done === 1'b1, {tag, " done"}, 64'(done), 1);
    chk(fault === exp_fault, {tag, " fault flag"}, 64'(fault), 64'(exp_fault));
    if (exp_fault) chk(code === exp_code, {tag, " fault code"}, 64'(code), 64'(exp_code));
    else begin
      chk(pa === exp_pa, {tag, " R6 pa"}, 64'(pa), 64'(exp_pa));
      chk(psize === exp_size, {tag, " R6 size"}, 64'(psize), 64'(exp_size));
    end
    rd = 0;
    foreach (log_a[i]) if (!log_w[i]) rd++;
    chk(rd == exp_rd.size(), {tag, " R2 read count"}, 64'(rd), 64'(exp_rd.size()));
    if (log_a.size() > 0 && !log_w[0])
      chk(log_a[0] === exp_rd[0], "R1 first read address", 64'(log_a[0]), 64'(exp_rd[0]));
    for (int i = 1; i < exp_rd.size() && i < log_a.size(); i++)
      chk(log_a[i] === exp_rd[i] && !log_w[i], "R2 next-level address", 64'(log_a[i]), 64'(exp_rd[i]));
    chk(log_a.size() == exp_rd.size() + (exp_wb ? 1 : 0), "R7 transaction count",
        64'(log_a.size()), 64'(exp_rd.size() + (exp_wb ? 1 : 0)));
    if (exp_wb && log_a.size() == exp_rd.size() + 1) begin
      chk(log_w[exp_rd.size()] === 1'b1 && log_a[exp_rd.size()] === exp_wba, "R7 write-back address",
          64'(log_a[exp_rd.size()]), 64'(exp_wba));
      chk(log_d[exp_rd.size()] === exp_wbd, "R7 write-back data",
          64'(log_d[exp_rd.size()]), 64'(exp_wbd));
    end
    @(negedge clk);
    chk(done === 1'b0, "R9 done is one pulse", 64'(done), 0);
  endtask

  task automatic run_bypass(input bit f, input bit b);
    logic [35:0] e;
    log_a.delete();
    va_r = $urandom;
    e = (f && b) ? (prom | 36'(va_r[18:0])) : 36'(va_r);
    @(negedge clk);
    start = 1; byp = 1; fetch = f; boot = b; va = va_r;
    @(negedge clk);
    start = 0; byp = 0;
    chk(done === 1'b1 && busy === 1'b0, "R8 bypass done next cycle", 64'(done), 1);
    chk(pa === e && psize === 2'd0, "R8 bypass pa", 64'(pa), 64'(e));
    @(negedge clk);
    chk(log_a.size() == 0, "R8 bypass no memory access", 64'(log_a.size()), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    start = 0; wr = 0; fetch = 0; byp = 0; boot = 0; va = '0; ptr = '0; ctx = '0;
    prom = 36'hF_F000_0000; err_en = 0; err_we = 0; err_addr = '0; wr_r = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && req === 1'b0, "R10 reset state", 64'({busy, done, req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_bypass(1, 1); run_bypass(0, 1); run_bypass(1, 0); run_bypass(0, 0);

    for (int l = 1; l <= 3; l++)
      for (int rm = 0; rm < 4; rm++)
        for (int w = 0; w < 2; w++) begin
          wr_r = 1'(w); build(l, 9, 0, rm); run("R6/R7 leaf", 0);
        end
    for (int l = 0; l <= 3; l++) begin
      wr_r = 0; build(3, l, 1, -1); run("R3 invalid entry", 0);
      build(3, l, 2, -1); run("R4 reserved entry", 0);
      build(3, l, 3, -1); run("R4 read bus error", 0);
    end
    build(2, 0, 5, -1); run("R5 leaf in context table", 0);
    build(3, 3, 5, -1); run("R5 directory at level 3", 0);
    wr_r = 1; build(2, 2, 4, -1); run("R4 write-back bus error", 0);
    wr_r = 0; build(3, 9, 0, -1); run("R9 start while busy ignored", 1);

    for (int it = 0; it < 150; it++) begin
      int lf = 1 + int'($urandom % 3);
      int k = int'($urandom % 8);
      wr_r = 1'($urandom);
      case (k)
        4: begin build(lf, int'($urandom % (lf + 1)), 1, -1); run("R3 random invalid", 0); end
        5: begin build(lf, int'($urandom % (lf + 1)), 2, -1); run("R4 random reserved", 0); end
        6: begin build(lf, int'($urandom % (lf + 1)), 3, -1); run("R4 random bus error", 0); end
        7: begin build(lf, lf, 4, -1); run("R4 random write-back error", 0); end
        default: begin build(lf, 9, 0, -1); run("R6 random walk", 0); end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule